// File: doc/BRIEF.md
# Character-Cell Scanline Pixel Generator

This block converts a text screen held in memory into the one-bit luma stream of a single visible video line. A sync generator supplies a one-cycle line-start pulse, the index of the line that pulse begins, and a flag that marks active video. From the line index the block derives a character row and a row within the glyph. It then reads one character code per column from a screen memory port. Each code addresses an 8-row font memory, and the returned glyph bytes are stored in a two-bank line buffer.

At a fixed tick count after the line start, the buffered bytes are shifted onto the luma pin. The leftmost column goes first, and within each byte the most significant bit goes first. Every pixel is held for a programmable number of clock ticks. Both memories are external and have a one-cycle synchronous read latency.

The fetch for a line runs in the horizontal blanking interval and writes the bank that serialization is not using. A fresh line start can therefore arrive while the previous line is still being shifted out.

Top module: `txt_scan_pixgen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, luma is low and neither memory read strobe is high.
- R2: For visible line L, screen address = (L div 8) * COLS + column and font address = {character code, L mod 8}. The code occupies address bits [10:3] and the glyph row occupies bits [2:0].
- R3: Screen reads for one line use column order 0 to COLS-1, and consecutive read cycles use consecutive addresses.
- R4: Pixel p of a line is bit (7 - p mod 8) of the glyph byte for column p div 8. Bit 7 is the leftmost pixel.
- R5: If line_start is sampled high at clock edge E, pixel 0 appears on luma after edge E+START_TICK, and luma is low between E and that edge.
- R6: Every pixel is held on luma for exactly PIX_TICKS clock cycles.
- R7: After the last pixel of column COLS-1, luma is driven low and stays low until the next line's pixel 0.
- R8: A line whose index is LINES or more issues no memory reads, and luma stays low for the whole of that line.
- R9: While active is low at a clock edge, luma is low after that edge, and the rest of the current line stays blank.
- R10: A visible line issues exactly COLS screen reads. Every screen read is followed in the next cycle by one font read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse marking tick 0 of a line |
| line_idx | input | LINE_W | Index of the line beginning at line_start |
| active | input | 1 | High during lines that carry video |
| scr_rd | output | 1 | Screen memory read strobe |
| scr_addr | output | SCR_AW | Screen memory address (row * COLS + column) |
| scr_data | input | 8 | Character code, valid one cycle after scr_rd |
| font_rd | output | 1 | Font memory read strobe |
| font_addr | output | 11 | Font address {code, glyph row} |
| font_data | input | 8 | Glyph row byte, valid one cycle after font_rd |
| luma | output | 1 | Serial black/white pixel output |

## Verification
The hardest situation to reach is the lowering of active partway through a line that is already being shifted. The block only clears its shift state on that signal, so the bench must time the change exactly. It drops the flag on the negative edge just before a chosen mid-line tick, then checks that every later tick of that line is dark. It then restores the flag and runs a normal line, which confirms that the next line starts cleanly.

The bench sweeps every line index up to and past the visible count, checking every tick of each line. This covers each glyph row, each character row and the invisible lines with the same expected-value arithmetic.

// File: rtl/txt_pkg.sv
package txt_pkg;
    localparam int GLYPH_BITS   = 3;                 // log2 of glyph height and width
    localparam int CHAR_PIX     = 1 << GLYPH_BITS;   // pixels per character cell
    localparam int CODE_W       = 8;
    localparam int FONT_AW      = CODE_W + GLYPH_BITS;
    typedef logic [CODE_W-1:0] glyph_t;
endpackage

// File: rtl/txt_fetch.sv
module txt_fetch
    import txt_pkg::*;
#(
    parameter int COLS   = 40,
    parameter int LINES  = 240,
    parameter int LINE_W = 9,
    parameter int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int SCR_AW = $clog2((LINES / CHAR_PIX) * COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_idx,
    input  logic              active,
    output logic              scr_rd,
    output logic [SCR_AW-1:0] scr_addr,
    input  glyph_t            scr_data,
    output logic              font_rd,
    output logic [FONT_AW-1:0] font_addr,
    input  glyph_t            font_data,
    input  logic              rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output glyph_t            rd_byte,
    output logic              line_on,
    output logic              wr_bank
);
    localparam int ROW_W = LINE_W - GLYPH_BITS;

    typedef struct packed {
        logic                  busy;
        logic [COL_W-1:0]      col;
        logic [ROW_W-1:0]      row;
        logic [GLYPH_BITS-1:0] grow;
        logic                  on;
        logic                  bank;
        logic                  s1_v;
        logic [COL_W-1:0]      s1_col;
        logic                  s2_v;
        logic [COL_W-1:0]      s2_col;
    } fst_t;

    fst_t q, d;
    glyph_t lbuf_q [2][COLS];

    always_comb begin
        d      = q;
        d.s1_v   = q.busy;
        d.s1_col = q.col;
        d.s2_v   = q.s1_v;
        d.s2_col = q.s1_col;
        if (line_start) begin
            d.on   = active && (line_idx < LINE_W'(LINES));
            d.busy = active && (line_idx < LINE_W'(LINES));
            d.col  = '0;
            d.row  = line_idx[LINE_W-1:GLYPH_BITS];
            d.grow = line_idx[GLYPH_BITS-1:0];
            d.bank = ~q.bank;
        end else if (q.busy) begin
            d.col = q.col + 1'b1;
            if (q.col == COL_W'(COLS - 1)) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Line buffer: two banks, written by the last pipeline stage
    always_ff @(posedge clk) begin
        if (q.s2_v) lbuf_q[q.bank][q.s2_col] <= font_data;
    end

    assign scr_rd    = q.busy;
    assign scr_addr  = SCR_AW'(int'(q.row) * COLS + int'(q.col));
    assign font_rd   = q.s1_v;
    assign font_addr = {scr_data, q.grow};
    assign rd_byte   = lbuf_q[rd_bank][rd_col];
    assign line_on   = q.on;
    assign wr_bank   = q.bank;
endmodule

// File: rtl/txt_shift.sv
module txt_shift
    import txt_pkg::*;
#(
    parameter int COLS       = 40,
    parameter int PIX_TICKS  = 5,
    parameter int START_TICK = 516,
    parameter int COL_W      = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             line_on,
    input  logic             wr_bank,
    input  logic             active,
    output logic             rd_bank,
    output logic [COL_W-1:0] rd_col,
    input  glyph_t           rd_byte,
    output logic             luma
);
    localparam int TICK_MAX = START_TICK + COLS * CHAR_PIX * PIX_TICKS + 1;
    localparam int TICK_W   = $clog2(TICK_MAX + 1);
    localparam int SUB_W    = (PIX_TICKS > 1) ? $clog2(PIX_TICKS) : 1;

    typedef struct packed {
        logic [TICK_W-1:0]     tick;
        logic                  run;
        logic                  bank;
        logic [COL_W-1:0]      col;
        logic [GLYPH_BITS-1:0] bit_i;
        logic [SUB_W-1:0]      sub;
        logic                  luma;
    } sst_t;

    sst_t q, d;

    always_comb begin
        d = q;
        if (line_start)                          d.tick = '0;
        else if (q.tick != TICK_W'(TICK_MAX))    d.tick = q.tick + 1'b1;

        if (q.run) begin
            if (q.sub == SUB_W'(PIX_TICKS - 1)) begin
                d.sub   = '0;
                d.bit_i = q.bit_i + 1'b1;
                if (q.bit_i == GLYPH_BITS'(CHAR_PIX - 1)) begin
                    d.col = q.col + 1'b1;
                    if (q.col == COL_W'(COLS - 1)) d.run = 1'b0;
                end
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end

        if (d.tick == TICK_W'(START_TICK) && line_on) begin
            d.run   = 1'b1;
            d.bank  = wr_bank;
            d.col   = '0;
            d.bit_i = '0;
            d.sub   = '0;
        end

        if (!active) d.run = 1'b0;

        rd_bank = d.bank;
        rd_col  = d.col;
        d.luma  = d.run & rd_byte[GLYPH_BITS'(CHAR_PIX - 1) - d.bit_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign luma = q.luma;
endmodule

// File: rtl/txt_scan_pixgen.sv
module txt_scan_pixgen
    import txt_pkg::*;
#(
    parameter int COLS       = 40,
    parameter int LINES      = 240,
    parameter int LINE_W     = 9,
    parameter int PIX_TICKS  = 5,
    parameter int START_TICK = 516,
    parameter int SCR_AW     = $clog2((LINES / CHAR_PIX) * COLS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic [LINE_W-1:0]  line_idx,
    input  logic               active,
    output logic               scr_rd,
    output logic [SCR_AW-1:0]  scr_addr,
    input  logic [7:0]         scr_data,
    output logic               font_rd,
    output logic [10:0]        font_addr,
    input  logic [7:0]         font_data,
    output logic               luma
);
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    // START_TICK must exceed COLS + 2 so the fetch completes before shifting.

    logic             rd_bank, line_on, wr_bank;
    logic [COL_W-1:0] rd_col;
    glyph_t           rd_byte;

    txt_fetch #(
        .COLS(COLS), .LINES(LINES), .LINE_W(LINE_W), .COL_W(COL_W), .SCR_AW(SCR_AW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_idx(line_idx),
        .active(active), .scr_rd(scr_rd), .scr_addr(scr_addr), .scr_data(scr_data),
        .font_rd(font_rd), .font_addr(font_addr), .font_data(font_data),
        .rd_bank(rd_bank), .rd_col(rd_col), .rd_byte(rd_byte),
        .line_on(line_on), .wr_bank(wr_bank)
    );

    txt_shift #(
        .COLS(COLS), .PIX_TICKS(PIX_TICKS), .START_TICK(START_TICK), .COL_W(COL_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_on(line_on),
        .wr_bank(wr_bank), .active(active), .rd_bank(rd_bank), .rd_col(rd_col),
        .rd_byte(rd_byte), .luma(luma)
    );
endmodule

// File: rtl/txt_scan_pixgen_chk.sv
module txt_scan_pixgen_chk #(
    parameter int LINES  = 240,
    parameter int LINE_W = 9,
    parameter int SCR_AW = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic [LINE_W-1:0] line_idx,
    input logic              active,
    input logic              scr_rd,
    input logic [SCR_AW-1:0] scr_addr,
    input logic              font_rd,
    input logic              luma
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!luma && !scr_rd && !font_rd));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_rd && $past(scr_rd) && !$past(line_start)) |-> scr_addr == SCR_AW'($past(scr_addr) + 1'b1));

    a_r8_no_fetch_offscreen: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && (line_idx >= LINE_W'(LINES))) |=> !scr_rd);

    a_r9_inactive_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !luma);

    a_r10_font_follows: assert property (@(posedge clk) disable iff (!rst_n)
        scr_rd |=> font_rd);
endmodule

bind txt_scan_pixgen txt_scan_pixgen_chk #(
    .LINES(LINES), .LINE_W(LINE_W), .SCR_AW(SCR_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_idx(line_idx),
    .active(active), .scr_rd(scr_rd), .scr_addr(scr_addr), .font_rd(font_rd),
    .luma(luma)
);

// File: tb/txt_scan_pixgen_tb.sv
module txt_scan_pixgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COLS   = 4;
    localparam int LINES  = 16;
    localparam int LINE_W = 9;
    localparam int PT     = 2;
    localparam int START  = 12;
    localparam int SCR_AW = $clog2((LINES / 8) * COLS);
    localparam int PIXELS = COLS * 8;
    localparam int LEN    = START + PIXELS * PT + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic [LINE_W-1:0] line_idx = '0;
    logic active = 1'b1;
    logic scr_rd, font_rd, luma;
    logic [SCR_AW-1:0] scr_addr;
    logic [10:0] font_addr;
    logic [7:0] scr_data = '0;
    logic [7:0] font_data = '0;
    int total = 0;
    int fails = 0;
    int rd_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txt_scan_pixgen #(
        .COLS(COLS), .LINES(LINES), .LINE_W(LINE_W), .PIX_TICKS(PT), .START_TICK(START)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_idx(line_idx),
        .active(active), .scr_rd(scr_rd), .scr_addr(scr_addr), .scr_data(scr_data),
        .font_rd(font_rd), .font_addr(font_addr), .font_data(font_data), .luma(luma)
    );

    function automatic logic [7:0] scr_fn(int a);
        return 8'((a * 29 + 5) & 255);
    endfunction

    function automatic logic [7:0] font_fn(int a);
        return 8'(((a * 53) ^ (a >> 2) ^ 90) & 255);
    endfunction

    // Memory models with one-cycle read latency
    always @(posedge clk) begin
        if (scr_rd)  scr_data  <= scr_fn(int'(scr_addr));
        if (font_rd) font_data <= font_fn(int'(font_addr));
        if (scr_rd)  rd_cnt    <= rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pix(int line, int n);
        int p, col, code, gbyte;
        if (line >= LINES || n < START || n >= START + PIXELS * PT) return 0;
        p     = (n - START) / PT;
        col   = p / 8;
        code  = int'(scr_fn((line / 8) * COLS + col));
        gbyte = int'(font_fn(code * 8 + line % 8));
        return (gbyte >> (7 - p % 8)) & 1;
    endfunction

    // drop: tick at which active goes low (-1 = never); act0: active low at line start
    task automatic run_line(input int line, input int drop, input bit act0);
        int rd0;
        int e;
        @(negedge clk);
        line_idx   = LINE_W'(line);
        line_start = 1'b1;
        active     = !act0;
        rd0        = rd_cnt;
        @(negedge clk);
        line_start = 1'b0;
        for (int n = 0; n < LEN; n++) begin
            e = (act0 || (drop >= 0 && n >= drop)) ? 0 : exp_pix(line, n);
            if (act0)                          chk(luma == e, "R9 inactive line", int'(luma), e);
            else if (drop >= 0 && n >= drop)   chk(luma == e, "R9 dropped active", int'(luma), e);
            else if (line >= LINES)            chk(luma == e, "R8 offscreen line", int'(luma), e);
            else if (n < START)                chk(luma == e, "R5 before start", int'(luma), e);
            else if (n >= START + PIXELS * PT) chk(luma == e, "R7 after last pixel", int'(luma), e);
            else if ((n - START) % PT != 0)    chk(luma == e, "R6 pixel hold", int'(luma), e);
            else                               chk(luma == e, "R2 R3 R4 pixel value", int'(luma), e);
            if (drop >= 0 && n + 1 == drop) active = 1'b0;
            @(negedge clk);
        end
        if (line >= LINES || act0) chk(rd_cnt - rd0 == 0, "R8 read count", rd_cnt - rd0, 0);
        else                       chk(rd_cnt - rd0 == COLS, "R10 read count", rd_cnt - rd0, COLS);
        active = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(luma == 1'b0, "R1 luma in reset", int'(luma), 0);
        chk(scr_rd == 1'b0, "R1 scr_rd in reset", int'(scr_rd), 0);
        chk(font_rd == 1'b0, "R1 font_rd in reset", int'(font_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(luma == 1'b0, "R1 luma after reset", int'(luma), 0);
        for (int l = 0; l < LINES + 3; l++) run_line(l, -1, 1'b0);
        run_line(300, -1, 1'b0);
        run_line(5, START + 11, 1'b0);
        run_line(6, -1, 1'b0);
        run_line(3, -1, 1'b1);
        run_line(LINES - 1, -1, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule